// File: doc/BRIEF.md
# Multi-Block Erase Sequencer with Polling Status

This block sequences a multi-block erase and produces the polling status byte that a host reads while the erase is under way. The first erase confirm opens a collection window. Each further confirm in the same bank adds its block to a selected-block bitmap and restarts the window. A confirm that names the other bank abandons the whole operation. When the window expires with no new confirm, a modelled erase of fixed length runs. The erase can be suspended and then resumed. While it is suspended, the remaining-time counter does not move.

A status read carries a block and a bank. If the read falls in the bank under operation, the block answers with a status byte. Otherwise the read is routed to the array. The status byte carries the following bits:

- bit 7: completion.
- bit 6: an operation toggle.
- bit 5: an error flag.
- bit 3: erase started.
- bit 2: a per-block toggle that inverts only for blocks in the selected set.

Failed blocks are identified after an injected failure through the per-block toggle. Durations are parameters in clock cycles.

Top module: `esq_top`

## Requirements
- R1: After reset, and whenever no operation is active, busy_o and suspended_o are 0, and a registered read reports rd_is_stat_o=0 with stat_o=8'h00 (array read).
- R2: A confirm in idle opens a collection window of WIN_CYC cycles. Each same-bank confirm during the window adds its block and restarts the window. The erase starts when the window expires, and with no suspend busy_o falls ERASE_CYC+WIN_CYC cycles after the last confirm.
- R3: stat_o bit 3 reads 0 for reads taken during the window and 1 for reads taken once erasure has started.
- R4: A confirm during the window whose bank differs from the first confirm's bank returns the block to idle and clears the selected set.
- R5: While the window, the erase or a failure is pending, stat_o bit 7 reads 0 and bit 6 inverts on every status read. After a successful erase, busy_o returns to 0.
- R6: Reads are status reads (rd_is_stat_o=1) only when qry_bank equals the operation's bank. Other reads return rd_is_stat_o=0 and stat_o=0.
- R7: stat_o bit 2 inverts on successive reads of a block in the selected set and reads 0 for other blocks in the bank.
- R8: Read/reset during the window aborts to idle. Once erasure has started, only suspend is accepted: confirms and read/reset neither add blocks, abort the operation, nor change its duration.
- R9: suspended_o rises SUSP_LAT cycles after the suspend request. While suspended, a read of a selected block returns bits 7 and 6 at 1, with bit 6 steady and bit 2 inverting. A read of an unselected block is an array read.
- R10: A resume whose bank matches the operation's bank continues the erase with the time left at suspension. A resume naming the other bank is ignored.
- R11: If fail_inj is high when the erase time runs out, the block enters a failed state. In that state busy_o stays 1, bit 5 reads 1, bit 7 reads 0, and bit 2 still identifies selected blocks. Only read/reset leaves this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfm_vld | input | 1 | Erase confirm strobe |
| cfm_blk | input | BW | Block named by the confirm |
| cfm_bank | input | 1 | Bank named by the confirm |
| susp_req | input | 1 | Suspend command |
| resume_req | input | 1 | Resume command |
| resume_bank | input | 1 | Bank addressed by the resume |
| rdrst_req | input | 1 | Read/reset command |
| fail_inj | input | 1 | Injected failure, sampled at erase end |
| qry_vld | input | 1 | Status read strobe |
| qry_blk | input | BW | Block addressed by the read |
| qry_bank | input | 1 | Bank addressed by the read |
| busy_o | output | 1 | An operation is active |
| suspended_o | output | 1 | Erase is suspended |
| rd_is_stat_o | output | 1 | Last read returned status (1) or array (0) |
| stat_o | output | 8 | Status byte of the last read |

## Verification
The hardest case to reach is a suspend whose remaining time must be preserved exactly. The stimulus has to land a suspend at a known point of the erase and hold the suspension for an arbitrary stretch. After a resume, the cycles to completion are then counted and compared with the value predicted from the suspend cycle, the latency and the window. A failed erase is also awkward: fail_inj must be held through completion before the bit 5 and bit 2 identification reads can be made. The bench reaches the collection window's restart boundary by placing a second confirm mid-window and then probing bit 3 on exactly the last window cycle and the first erase cycle.

// File: rtl/esq_pkg.sv
package esq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN,
        ST_ERASE,
        ST_SPWAIT,
        ST_SUSP,
        ST_FAIL
    } esq_state_e;

    // status byte bit positions
    localparam int SB_DONE    = 7;
    localparam int SB_OPTOG   = 6;
    localparam int SB_ERR     = 5;
    localparam int SB_STARTED = 3;
    localparam int SB_BLKTOG  = 2;
endpackage

// File: rtl/esq_blkset.sv
module esq_blkset #(
    parameter int NB = 8,
    parameter int BW = 3
) (
    input  logic [NB-1:0] set_q,
    input  logic [BW-1:0] add_blk,
    input  logic [BW-1:0] qry_blk,
    output logic [NB-1:0] add_mask,
    output logic [NB-1:0] set_with,
    output logic          hit
);
    logic [NB-1:0] hit_vec;

    for (genvar g = 0; g < NB; g++) begin : g_bit
        assign add_mask[g] = (add_blk == BW'(g));
        assign set_with[g] = set_q[g] | add_mask[g];
        assign hit_vec[g]  = set_q[g] & (qry_blk == BW'(g));
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/esq_status.sv
module esq_status
    import esq_pkg::*;
(
    input  esq_state_e  fsm,
    input  logic        same_bank,
    input  logic        hit,
    input  logic        t6,
    input  logic        t2,
    output logic        is_stat,
    output logic [7:0]  sbyte,
    output logic        flip6,
    output logic        flip2
);
    always_comb begin
        is_stat = 1'b0;
        sbyte   = 8'h00;
        flip6   = 1'b0;
        flip2   = 1'b0;
        unique case (fsm)
            ST_WIN, ST_ERASE, ST_SPWAIT, ST_FAIL: begin
                if (same_bank) begin
                    is_stat            = 1'b1;
                    sbyte[SB_OPTOG]    = t6;
                    flip6              = 1'b1;
                    sbyte[SB_ERR]      = (fsm == ST_FAIL);
                    sbyte[SB_STARTED]  = (fsm != ST_WIN);
                    if (hit) begin
                        sbyte[SB_BLKTOG] = t2;
                        flip2            = 1'b1;
                    end
                end
            end
            ST_SUSP: begin
                if (same_bank && hit) begin
                    is_stat           = 1'b1;
                    sbyte[SB_DONE]    = 1'b1;
                    sbyte[SB_OPTOG]   = 1'b1;
                    sbyte[SB_STARTED] = 1'b1;
                    sbyte[SB_BLKTOG]  = t2;
                    flip2             = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/esq_top.sv
module esq_top
    import esq_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int WIN_CYC    = 20,
    parameter int ERASE_CYC  = 40,
    parameter int SUSP_LAT   = 4,
    localparam int BW        = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfm_vld,
    input  logic [BW-1:0] cfm_blk,
    input  logic          cfm_bank,
    input  logic          susp_req,
    input  logic          resume_req,
    input  logic          resume_bank,
    input  logic          rdrst_req,
    input  logic          fail_inj,
    input  logic          qry_vld,
    input  logic [BW-1:0] qry_blk,
    input  logic          qry_bank,
    output logic          busy_o,
    output logic          suspended_o,
    output logic          rd_is_stat_o,
    output logic [7:0]    stat_o
);
    localparam int CNT_MAX = (WIN_CYC > SUSP_LAT) ? WIN_CYC : SUSP_LAT;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int EW      = $clog2(ERASE_CYC + 1);
    localparam logic [CW-1:0] WIN_RLD = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] LAT_RLD = CW'(SUSP_LAT - 1);
    localparam logic [EW-1:0] ERS_RLD = EW'(ERASE_CYC - 1);

    typedef struct packed {
        esq_state_e            fsm;
        logic                  bank;
        logic [NUM_BLOCKS-1:0] set;
        logic [CW-1:0]         cnt;
        logic [EW-1:0]         ers;
        logic                  t6;
        logic                  t2;
        logic                  is_stat;
        logic [7:0]            stat;
    } esq_regs_t;

    esq_regs_t cur_q, nxt_d;

    logic [NUM_BLOCKS-1:0] add_mask, set_with;
    logic                  hit;
    logic                  f_is, f6, f2;
    logic [7:0]            f_byte;

    esq_blkset #(.NB(NUM_BLOCKS), .BW(BW)) u_set (
        .set_q    (cur_q.set),
        .add_blk  (cfm_blk),
        .qry_blk  (qry_blk),
        .add_mask (add_mask),
        .set_with (set_with),
        .hit      (hit)
    );

    esq_status u_fmt (
        .fsm       (cur_q.fsm),
        .same_bank (qry_bank == cur_q.bank),
        .hit       (hit),
        .t6        (cur_q.t6),
        .t2        (cur_q.t2),
        .is_stat   (f_is),
        .sbyte     (f_byte),
        .flip6     (f6),
        .flip2     (f2)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.fsm)
            ST_IDLE: begin
                if (cfm_vld) begin
                    nxt_d.fsm  = ST_WIN;
                    nxt_d.bank = cfm_bank;
                    nxt_d.set  = add_mask;
                    nxt_d.cnt  = WIN_RLD;
                end
            end
            ST_WIN: begin
                if (rdrst_req || (cfm_vld && cfm_bank != cur_q.bank)) begin
                    nxt_d.fsm = ST_IDLE;
                    nxt_d.set = '0;
                end else if (cfm_vld) begin
                    nxt_d.set = set_with;
                    nxt_d.cnt = WIN_RLD;
                end else if (cur_q.cnt == '0) begin
                    nxt_d.fsm = ST_ERASE;
                    nxt_d.ers = ERS_RLD;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            ST_ERASE, ST_SPWAIT: begin
                if (cur_q.ers == '0) begin
                    nxt_d.fsm = fail_inj ? ST_FAIL : ST_IDLE;
                    if (!fail_inj) nxt_d.set = '0;
                end else begin
                    nxt_d.ers = cur_q.ers - 1'b1;
                    if (cur_q.fsm == ST_ERASE) begin
                        if (susp_req) begin
                            nxt_d.fsm = ST_SPWAIT;
                            nxt_d.cnt = LAT_RLD;
                        end
                    end else if (cur_q.cnt == '0) begin
                        nxt_d.fsm = ST_SUSP;
                    end else begin
                        nxt_d.cnt = cur_q.cnt - 1'b1;
                    end
                end
            end
            ST_SUSP: begin
                if (resume_req && resume_bank == cur_q.bank) nxt_d.fsm = ST_ERASE;
            end
            ST_FAIL: begin
                if (rdrst_req) begin
                    nxt_d.fsm = ST_IDLE;
                    nxt_d.set = '0;
                end
            end
            default: nxt_d.fsm = ST_IDLE;
        endcase

        if (qry_vld) begin
            nxt_d.is_stat = f_is;
            nxt_d.stat    = f_byte;
            if (f6) nxt_d.t6 = ~cur_q.t6;
            if (f2) nxt_d.t2 = ~cur_q.t2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q     <= '0;
            cur_q.fsm <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o       = (cur_q.fsm != ST_IDLE);
    assign suspended_o  = (cur_q.fsm == ST_SUSP);
    assign rd_is_stat_o = cur_q.is_stat;
    assign stat_o       = cur_q.stat;
endmodule

// File: rtl/esq_chk.sv
module esq_chk
    import esq_pkg::*;
#(
    parameter int EW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          suspended,
    input logic          is_stat,
    input logic [7:0]    stat,
    input logic          qry_vld,
    input logic          cfm_vld,
    input logic          cfm_bank,
    input logic          rdrst_req,
    input logic          resume_req,
    input esq_state_e    fsm,
    input logic          bank,
    input logic [EW-1:0] ers
);
    AST_IDLE_NOT_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !suspended); // R1
    AST_ARRAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !is_stat |-> stat == 8'h00); // R6
    AST_WIN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_WIN && cfm_vld && cfm_bank != bank) |=> !busy); // R4
    AST_ERASE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_ERASE && ers != '0 && (rdrst_req || cfm_vld)) |=> busy); // R8
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm == ST_SUSP && !resume_req) |=> $stable(ers)); // R10
    AST_SUSP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(suspended) && $past(qry_vld) && is_stat) |-> (stat[7] && stat[6])); // R9
    AST_SUSP_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(busy)); // R9
    AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (is_stat && stat[5]) |-> !stat[7]); // R11
endmodule

bind esq_top esq_chk #(.EW(EW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy_o),
    .suspended  (suspended_o),
    .is_stat    (rd_is_stat_o),
    .stat       (stat_o),
    .qry_vld    (qry_vld),
    .cfm_vld    (cfm_vld),
    .cfm_bank   (cfm_bank),
    .rdrst_req  (rdrst_req),
    .resume_req (resume_req),
    .fsm        (cur_q.fsm),
    .bank       (cur_q.bank),
    .ers        (cur_q.ers)
);

// File: tb/esq_top_bench.sv
`timescale 1ns/1ps
module esq_top_bench;
    localparam int WIN = 6;
    localparam int ERA = 12;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfm_vld = 0, cfm_bank = 0, susp_req = 0, resume_req = 0, resume_bank = 0;
    logic rdrst_req = 0, fail_inj = 0, qry_vld = 0, qry_bank = 0;
    logic [2:0] cfm_blk = '0, qry_blk = '0;
    logic busy_o, suspended_o, rd_is_stat_o;
    logic [7:0] stat_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    esq_top #(.NUM_BLOCKS(8), .WIN_CYC(WIN), .ERASE_CYC(ERA), .SUSP_LAT(LAT)) u_esq_top (
        .clk(clk), .rst_n(rst_n), .cfm_vld(cfm_vld), .cfm_blk(cfm_blk), .cfm_bank(cfm_bank),
        .susp_req(susp_req), .resume_req(resume_req), .resume_bank(resume_bank),
        .rdrst_req(rdrst_req), .fail_inj(fail_inj), .qry_vld(qry_vld), .qry_blk(qry_blk),
        .qry_bank(qry_bank), .busy_o(busy_o), .suspended_o(suspended_o),
        .rd_is_stat_o(rd_is_stat_o), .stat_o(stat_o)
    );

    typedef struct packed {
        logic       cfm;
        logic [2:0] blk;
        logic       bnk;
        logic       qry;
        logic [2:0] qb;
        logic       qk;
        logic       busy;
        logic       isst;
        logic [7:0] val;
        logic [7:0] msk;
    } vec_t;

    function automatic vec_t mkv(int c, int b, int k, int q, int qb, int qk,
                                 int bz, int is, int val, int msk);
        vec_t r;
        r.cfm = c[0]; r.blk = b[2:0]; r.bnk = k[0]; r.qry = q[0];
        r.qb = qb[2:0]; r.qk = qk[0]; r.busy = bz[0]; r.isst = is[0];
        r.val = val[7:0]; r.msk = msk[7:0];
        return r;
    endfunction

    // rows tuned for WIN=6
    localparam vec_t VECS [14] = '{
        mkv(0,0,0, 1,0,0, 0,0, 'h00,'hFF), // R1 R6 idle read is array
        mkv(1,2,0, 0,0,0, 1,0, 'h00,'h00), // R2 first confirm
        mkv(0,0,0, 1,2,0, 1,1, 'h00,'hA8), // R3 R5 window status
        mkv(0,0,0, 1,5,0, 1,1, 'h00,'hAC), // R7 unselected block
        mkv(0,0,0, 1,1,1, 1,0, 'h00,'hFF), // R6 other bank
        mkv(1,5,0, 0,0,0, 1,0, 'h00,'h00), // R2 restart
        mkv(0,0,0, 0,0,0, 1,0, 'h00,'h00),
        mkv(0,0,0, 0,0,0, 1,0, 'h00,'h00),
        mkv(0,0,0, 0,0,0, 1,0, 'h00,'h00),
        mkv(0,0,0, 0,0,0, 1,0, 'h00,'h00),
        mkv(0,0,0, 0,0,0, 1,0, 'h00,'h00),
        mkv(0,0,0, 1,5,0, 1,1, 'h00,'hA8), // R3 last window cycle
        mkv(0,0,0, 1,5,0, 1,1, 'h08,'hA8), // R3 erase started
        mkv(0,0,0, 1,1,1, 1,0, 'h00,'hFF)  // R6
    };

    task automatic tick();
        @(posedge clk);
        #1;
        cfm_vld = 0; susp_req = 0; resume_req = 0; rdrst_req = 0; qry_vld = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; fail_inj = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic confirm(input int b, input int k);
        cfm_vld = 1; cfm_blk = b[2:0]; cfm_bank = k[0];
        tick();
    endtask

    task automatic query(input int b, input int k);
        qry_vld = 1; qry_blk = b[2:0]; qry_bank = k[0];
        tick();
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy_o && n < 500) begin
            tick();
            n++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] s0, s1, s2;
        do_reset();
        chk(busy_o == 0 && suspended_o == 0, "R1 reset flags", {busy_o, suspended_o}, 0);
        chk(rd_is_stat_o == 0 && stat_o == 0, "R1 reset status", stat_o, 0);

        // table walk
        for (int i = 0; i < 14; i++) begin
            cfm_vld = VECS[i].cfm; cfm_blk = VECS[i].blk; cfm_bank = VECS[i].bnk;
            qry_vld = VECS[i].qry; qry_blk = VECS[i].qb; qry_bank = VECS[i].qk;
            tick();
            chk(busy_o == VECS[i].busy, $sformatf("R2 vec%0d busy", i), busy_o, VECS[i].busy);
            if (VECS[i].qry) begin
                chk(rd_is_stat_o == VECS[i].isst, $sformatf("R6 vec%0d is_stat", i),
                    rd_is_stat_o, VECS[i].isst);
                chk((stat_o & VECS[i].msk) == VECS[i].val, $sformatf("R3 vec%0d stat", i),
                    stat_o & VECS[i].msk, VECS[i].val);
            end
        end

        // R2 R5 erase length from single confirm
        do_reset();
        confirm(0, 0);
        count_busy(n);
        chk(n == WIN + ERA, "R2 R5 length", n, WIN + ERA);

        // R2 restart extends from the last confirm
        do_reset();
        confirm(0, 0); tick(); tick(); tick();
        confirm(1, 0);
        count_busy(n);
        chk(n == WIN + ERA, "R2 restart length", n, WIN + ERA);

        // R5 R7 toggles
        do_reset();
        confirm(3, 0);
        query(3, 0); s0 = stat_o;
        query(3, 0); s1 = stat_o;
        query(4, 0); s2 = stat_o;
        chk(s0[6] != s1[6] && s1[6] != s2[6], "R5 op toggle", {s0[6], s1[6], s2[6]}, 3'b010);
        chk(s0[2] != s1[2], "R7 block toggle", {s0[2], s1[2]}, 2'b01);
        chk(s2[2] == 0, "R7 unselected bit2", s2[2], 0);
        chk(s0[7] == 0, "R5 done low", s0[7], 0);

        // R4 bank abort
        do_reset();
        confirm(1, 0);
        confirm(3, 1);
        chk(busy_o == 0, "R4 abort busy", busy_o, 0);
        query(1, 0);
        chk(rd_is_stat_o == 0, "R4 set cleared", rd_is_stat_o, 0);

        // R8 read/reset in window
        do_reset();
        confirm(2, 0);
        rdrst_req = 1; tick();
        chk(busy_o == 0, "R8 rdrst in window", busy_o, 0);

        // R8 commands ignored once erasing
        do_reset();
        confirm(0, 0);
        for (int i = 0; i < WIN; i++) tick();
        rdrst_req = 1; tick();
        chk(busy_o == 1, "R8 rdrst ignored", busy_o, 1);
        confirm(7, 0);
        confirm(4, 1);
        chk(busy_o == 1, "R8 other bank ignored", busy_o, 1);
        query(7, 0); s0 = stat_o;
        query(7, 0); s1 = stat_o;
        chk(s0[2] == 0 && s1[2] == 0, "R8 late block not added", {s0[2], s1[2]}, 0);
        count_busy(n);
        chk(n == WIN + ERA - 11, "R8 duration kept", n, WIN + ERA - 11);

        // R9 R10 suspend and resume
        do_reset();
        confirm(2, 0);                       // E0
        for (int i = 0; i < 7; i++) tick();  // E1..E7
        susp_req = 1; tick();                // E8
        tick(); tick();                      // E9, E10
        chk(suspended_o == 0, "R9 latency early", suspended_o, 0);
        tick();                              // E11
        chk(suspended_o == 1, "R9 suspended", suspended_o, 1);
        query(2, 0); s0 = stat_o;
        chk(rd_is_stat_o == 1 && (s0 & 8'hE8) == 8'hC8, "R9 suspend status", s0 & 8'hE8, 8'hC8);
        query(2, 0); s1 = stat_o;
        chk(s1[6] == 1 && s0[2] != s1[2], "R9 bit6 held bit2 toggles", {s1[6], s0[2], s1[2]}, 3'b101);
        query(5, 0);
        chk(rd_is_stat_o == 0, "R9 unselected array", rd_is_stat_o, 0);
        resume_req = 1; resume_bank = 1; tick();  // E15
        chk(suspended_o == 1, "R10 wrong bank resume", suspended_o, 1);
        for (int i = 0; i < 5; i++) tick();  // E16..E20
        resume_req = 1; resume_bank = 0; tick(); // E21
        chk(suspended_o == 0 && busy_o == 1, "R10 resumed", {suspended_o, busy_o}, 1);
        count_busy(n);
        chk(n == ERA + WIN - 8 - LAT, "R10 remaining time", n, ERA + WIN - 8 - LAT);

        // R11 failure
        do_reset();
        fail_inj = 1;
        confirm(6, 0);
        for (int i = 0; i < WIN + ERA + 2; i++) tick();
        chk(busy_o == 1, "R11 busy held", busy_o, 1);
        query(6, 0); s0 = stat_o;
        chk((s0 & 8'hA8) == 8'h28, "R11 error status", s0 & 8'hA8, 8'h28);
        query(6, 0); s1 = stat_o;
        chk(s0[2] != s1[2], "R11 failed block id", {s0[2], s1[2]}, 2'b01);
        query(1, 0); s2 = stat_o;
        chk(s2[2] == 0 && s2[5] == 1, "R11 other block", {s2[5], s2[2]}, 2'b10);
        fail_inj = 0;
        susp_req = 1; tick();
        chk(busy_o == 1, "R11 suspend ignored", busy_o, 1);
        rdrst_req = 1; tick();
        chk(busy_o == 0, "R11 rdrst clears", busy_o, 0);

        // R1 reset mid-operation
        confirm(2, 0);
        do_reset();
        chk(busy_o == 0 && suspended_o == 0, "R1 reset aborts", busy_o, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule